// File: doc/BRIEF.md
# Serial Controller Input Port

This block is the read side of a game-controller port that acts as an eight-bit shift register. While the strobe level is high, the register keeps loading the parallel button state. While the strobe is low, some read cycles to the port address clock the register. Each clocking read moves the next button bit onto the serial output, and a one fills in from the top. Once every button bit has been shifted out, the port returns one on every later read.

The block watches the processor bus every cycle. It sees whether the port address is selected and whether the cycle is a read, and it decides which of those read cycles clock the register.

A parameter selects between two silicon revisions:

- **First-read-only revision.** Only the first cycle of a run of back-to-back read cycles clocks the register.
- **Every-cycle revision.** Every read cycle clocks the register. A read that a DMA halt stretches over several cycles therefore loses one button bit per extra cycle.

Top module: `serial_pad_port`

## Requirements
- R1: After reset, with the strobe low, `data_o` is 1 and reads keep returning 1.
- R2: While `strobe_i` is high, `data_o` follows `btn_i[0]` in the same cycle. Read cycles do not advance the register, and the last clock edge with the strobe high captures `btn_i`.
- R3: After the strobe falls, the first clocking read returns the captured bit 0.
- R4: Clocking reads present the captured bits least significant first. `data_o` shows bit k before the (k+1)-th clocking read's edge.
- R5: After eight clocking reads, every further read returns 1.
- R6: A cycle with `sel_i` high and `rd_i` low, or with `rd_i` high and `sel_i` low, does not advance the register.
- R7: With `EVERY_CYCLE`=0, a run of consecutive read-hit cycles advances the register exactly once.
- R8: With `EVERY_CYCLE`=1, each read-hit cycle advances the register, consecutive or not.
- R9: With `EVERY_CYCLE`=0, a read hit that follows at least one idle cycle advances the register again. A four-cycle stretched read therefore costs one shift in this revision and four in the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one edge per bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_i | input | NBITS | Parallel button state, bit 0 shifted out first |
| strobe_i | input | 1 | Strobe level; high reloads the register |
| sel_i | input | 1 | Port address matches this cycle |
| rd_i | input | 1 | Current bus cycle is a read |
| data_o | output | 1 | Serial data bit returned to the reader |

## Verification
The serial bit is combinational from the register and the strobe. Each read's value is therefore due in the same cycle as the read, before the edge that may shift. Any shift shows up from the following cycle on.

The bench drives inputs on the falling edge and samples `data_o` a quarter period later, ahead of the next rising edge. Each sampled value therefore reflects all edges up to the previous cycle.

Both revisions are instantiated side by side and run on the same stimulus. A single sequence thus shows the difference between one shift per run and one shift per cycle.

// File: rtl/serial_pad_port.sv
module serial_pad_port #(
  parameter int NBITS       = 8,
  parameter bit EVERY_CYCLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] btn_i,
  input  logic             strobe_i,
  input  logic             sel_i,
  input  logic             rd_i,
  output logic             data_o
);
  localparam logic [NBITS-1:0] ALL_ONES = '1;

  logic [NBITS-1:0] sr;
  logic             hit;
  logic             hit_q;
  logic             shift_en;

  assign hit = sel_i & rd_i;

  generate
    if (EVERY_CYCLE) begin : g_every
      assign shift_en = hit;

      // R8
      every_cycle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !strobe_i && sr != ALL_ONES |=> sr != $past(sr));
    end else begin : g_first
      assign shift_en = hit & ~hit_q;

      // R7
      run_single_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q && hit && !strobe_i |=> $stable(sr));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= ALL_ONES;
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit;
      if (strobe_i)
        sr <= btn_i;
      else if (shift_en)
        sr <= {1'b1, sr[NBITS-1:1]};
    end
  end

  assign data_o = strobe_i ? btn_i[0] : sr[0];

  // R2
  strobe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> sr == $past(btn_i));

  // R5
  drained_stays_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i && sr == ALL_ONES |=> sr == ALL_ONES);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i && !hit |=> $stable(sr));

  // R4
  fill_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i && hit |=> sr[NBITS-1]);
endmodule

// File: tb/tb_serial_pad_port.sv
module tb_serial_pad_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] btn = 8'h00;
  logic       stb = 1'b0;
  logic       sel = 1'b0;
  logic       rd = 1'b0;
  logic       out_a, out_b;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  serial_pad_port #(.NBITS(8), .EVERY_CYCLE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .btn_i(btn), .strobe_i(stb),
    .sel_i(sel), .rd_i(rd), .data_o(out_a));

  serial_pad_port #(.NBITS(8), .EVERY_CYCLE(1'b1)) dut_ec (
    .clk(clk), .rst_n(rst_n), .btn_i(btn), .strobe_i(stb),
    .sel_i(sel), .rd_i(rd), .data_o(out_b));

  // {strobe, sel, rd, expected first-read-only, expected every-cycle}, btn = A5
  localparam int NVEC = 21;
  localparam logic [4:0] VEC [0:NVEC-1] = '{
    5'b100_11,  // 0  R2 strobe high shows bit0
    5'b011_11,  // 1  R3 first read bit0
    5'b011_00,  // 2  R7/R8 run continues
    5'b011_01,  // 3  R8 every-cycle shifted again
    5'b000_00,  // 4
    5'b011_00,  // 5  R9 new run counts
    5'b010_10,  // 6  R6 sel without rd
    5'b001_10,  // 7  R6 rd without sel
    5'b011_10,  // 8  R4
    5'b000_01,  // 9
    5'b011_01,  // 10 R4
    5'b000_00,  // 11
    5'b011_00,  // 12 R4
    5'b000_11,  // 13
    5'b011_11,  // 14 R4
    5'b000_01,  // 15
    5'b011_01,  // 16 R4
    5'b000_11,  // 17
    5'b011_11,  // 18 R4 bit7
    5'b000_11,  // 19
    5'b011_11   // 20 R5 drained
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic s, input logic se, input logic r);
    @(negedge clk);
    stb = s; sel = se; rd = r;
    #5;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1 reset first-read", out_a, 1'b1);
    chk("R1 reset every-cycle", out_b, 1'b1);
    cyc(1'b0, 1'b1, 1'b1);
    chk("R1 read after reset", out_a, 1'b1);
    chk("R1 read after reset ec", out_b, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);

    btn = 8'hA5;
    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][4], VEC[i][3], VEC[i][2]);
      chk($sformatf("R4/R7/R8 vector %0d first-read", i), out_a, VEC[i][1]);
      chk($sformatf("R4/R7/R8 vector %0d every-cycle", i), out_b, VEC[i][0]);
    end

    // R2: strobe high tracks btn and reads do not shift
    btn = 8'hFE;
    cyc(1'b1, 1'b1, 1'b1);
    chk("R2 strobe tracks 0", out_a, 1'b0);
    btn = 8'h01;
    #1;
    chk("R2 strobe tracks 1", out_b, 1'b1);
    btn = 8'h02;
    cyc(1'b1, 1'b1, 1'b1);
    chk("R2 strobe read no shift", out_a, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R3 captured bit0", out_a, 1'b0);
    cyc(1'b0, 1'b1, 1'b1);
    chk("R3 first read bit0", out_b, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R3 next bit1", out_a, 1'b1);
    chk("R3 next bit1 ec", out_b, 1'b1);

    // R9: four-cycle stretched read, btn bit1 and bit4 set
    btn = 8'h12;
    cyc(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R9 stall costs one shift", out_a, 1'b1);
    chk("R8 stall costs four shifts", out_b, 1'b1);
    cyc(1'b0, 1'b1, 1'b1);
    chk("R9 next read bit1", out_a, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R9 after gap bit2", out_a, 1'b0);
    chk("R8 after stall bit5", out_b, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule